// File: doc/BRIEF.md
# Selectable-Source Clock Prescaler

This block is a shared clock divider that gives several timer channels a common slow time base. It takes source events from one of four places and counts them down with a 14-bit counter. Each time the counter passes through zero it emits a one-cycle clock-enable pulse, which the timer channels can use in place of their own source. The events come either from an internal half-rate strobe, true on every second cycle of the system clock, or from a rising edge on one of three external timer pins. Each pin goes through a two-flop synchronizer and an edge detector inside the block. A pin can be chosen whatever the timer that owns it is doing. An external pin must toggle slower than a quarter of the system clock so that no edge is lost.

Software sets the block up with one 16-bit configuration word, written over a simple write strobe. The top two bits of the word pick the source and the low 14 bits hold the divide factor F. The block outputs this configuration word and the live counter value, with the counter value zero-extended to 16 bits. Writing the word also preloads the counter with F. A tick therefore arrives once every F+1 source events.

Top module: `tmr_prescaler`

## Requirements
- R1: While reset is held, the configuration output, the count output and the tick output are all zero.
- R2: A cycle with `cfg_wr` high stores all 16 bits of `cfg_wdata`, and `load_o` shows them after the next clock edge. Bits [15:14] are the source selector and bits [13:0] are the divide factor F.
- R3: A write loads the counter with the new F, which `cnt_o` shows after the same edge. A write produces no tick, and an event in the same cycle as a write is dropped.
- R4: When there is no write, each source event decrements the counter by one. An event that finds the counter at zero instead reloads it with F and raises `tick_o` for one cycle at the same edge. The division ratio is F+1.
- R5: Selector 00 picks the internal source, which gives one event every second clock. Ticks then come exactly 2*(F+1) cycles apart.
- R6: Selectors 01, 10 and 11 pick pins 0, 1 and 2. A rising edge of the chosen pin is one event. When the pin is set before clock edge k, `cnt_o` changes at edge k+2 and not before.
- R7: A pin that is not selected has no effect on the counter or on the tick.
- R8: `cnt_o[15:14]` always reads zero, and `cnt_o[13:0]` never exceeds the stored F.
- R9: `tick_o` is never high in two cycles in a row.
- R10: The boundary values of F both work. F=0 ticks on every event, and F=16383 ticks every 32768 cycles when the internal source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word: selector [15:14], factor [13:0] |
| pin_i | input | 3 | Asynchronous external timer pins |
| load_o | output | 16 | Stored configuration word |
| cnt_o | output | 16 | Live counter value, zero-extended |
| tick_o | output | 1 | One-cycle prescaled clock enable |

## Verification
After a write, `load_o` and `cnt_o` are due at the next clock edge, so the bench drives the write on a falling edge and checks at the following falling edge. A pin edge reaches the counter two edges after it is sampled. The bench checks `cnt_o` at one falling edge and then the next to show that the value is unchanged and then updated. The internal source starts at a phase that depends on how long the block has been out of reset. For that reason the internal-source checks measure the cycle distance between two ticks that follow each other, and they do not time the first tick after a write. Pin-driven tests wait several cycles after each pulse before they compare the count and the tick total, so every pipeline stage has settled.

// File: rtl/tpre_pkg.sv
package tpre_pkg;

  typedef enum logic [1:0] {
    SRC_HALF = 2'b00,
    SRC_PIN0 = 2'b01,
    SRC_PIN1 = 2'b10,
    SRC_PIN2 = 2'b11
  } src_sel_e;

endpackage

// File: rtl/tpre_edge_sync.sv
module tpre_edge_sync #(
  parameter int NPIN   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] rise_o
);
  localparam int DEPTH = STAGES + 1;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [DEPTH-1:0] shf_q;
    logic [DEPTH-1:0] shf_d;

    always_comb begin
      shf_d = {shf_q[DEPTH-2:0], pin_i[p]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shf_q <= '0;
      else        shf_q <= shf_d;
    end

    assign rise_o[p] = shf_q[DEPTH-2] & ~shf_q[DEPTH-1];
  end

endmodule

// File: rtl/tpre_src_sel.sv
module tpre_src_sel #(
  parameter int NPIN  = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NPIN-1:0]  rise_i,
  output logic             ev_o
);
  logic half_q;
  logic half_d;

  always_comb begin
    half_d = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  always_comb begin
    ev_o = 1'b0;
    if (sel_i == '0) begin
      ev_o = half_q;
    end else begin
      for (int i = 0; i < NPIN; i++) begin
        if (int'(sel_i) == i + 1) ev_o = rise_i[i];
      end
    end
  end

endmodule

// File: rtl/tpre_divider.sv
module tpre_divider #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             ev_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (ev_i) begin
      if (at_zero) begin
        cnt_d  = ld_val_i;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int REG_W  = 16,
  parameter int CNT_W  = 14,
  parameter int NPIN   = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [NPIN-1:0]  pin_i,
  output logic [REG_W-1:0] load_o,
  output logic [REG_W-1:0] cnt_o,
  output logic             tick_o
);
  import tpre_pkg::*;

  localparam int SEL_W = REG_W - CNT_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [REG_W-1:0] load_q, load_d;
  logic [NPIN-1:0]  rise;
  logic             ev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ld_val;
  logic [SEL_W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    load_d = load_q;
    if (cfg_wr) load_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) load_q <= '0;
    else            load_q <= load_d;
  end

  assign sel    = load_q[REG_W-1:CNT_W];
  assign ld_val = cfg_wr ? cfg_wdata[CNT_W-1:0] : load_q[CNT_W-1:0];

  tpre_edge_sync #(.NPIN(NPIN), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin_i (pin_i),
    .rise_o(rise)
  );

  tpre_src_sel #(.NPIN(NPIN), .SEL_W(SEL_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sel_i (sel),
    .rise_i(rise),
    .ev_o  (ev)
  );

  tpre_divider #(.CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ld_i    (cfg_wr),
    .ld_val_i(ld_val),
    .ev_i    (ev),
    .cnt_o   (cnt),
    .tick_o  (tick_o)
  );

  assign load_o = load_q;
  assign cnt_o  = {{SEL_W{1'b0}}, cnt};

endmodule

// File: rtl/tpre_checker.sv
module tpre_checker #(
  parameter int REG_W = 16,
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] load_o,
  input logic [REG_W-1:0] cnt_o,
  input logic             tick_o
);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> load_o == $past(cfg_wdata));

  // R3
  write_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cnt_o[CNT_W-1:0] == $past(cfg_wdata[CNT_W-1:0])) && !tick_o);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> (cnt_o == $past(cnt_o)) ||
                (cnt_o == $past(cnt_o) - 1'b1) ||
                (tick_o && $past(cnt_o) == '0));

  // R4
  tick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> cnt_o[CNT_W-1:0] == load_o[CNT_W-1:0]);

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o[REG_W-1:CNT_W] == '0) && (cnt_o[CNT_W-1:0] <= load_o[CNT_W-1:0]));

  // R9
  tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

bind tmr_prescaler tpre_checker #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .cfg_wdata(cfg_wdata),
  .load_o   (load_o),
  .cnt_o    (cnt_o),
  .tick_o   (tick_o)
);

// File: tb/sim_tmr_prescaler.sv
`timescale 1ns/1ps
module sim_tmr_prescaler;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [15:0] cfg_wdata;
  logic [2:0]  pin_i;
  logic [15:0] load_o;
  logic [15:0] cnt_o;
  logic        tick_o;

  int checks;
  int failures;
  int cyc;
  int ticks;
  int last_tick_cyc;
  int prev_tick_cyc;

  tmr_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .pin_i(pin_i), .load_o(load_o), .cnt_o(cnt_o), .tick_o(tick_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tick_o) begin
      ticks         = ticks + 1;
      prev_tick_cyc = last_tick_cyc;
      last_tick_cyc = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic pulse_pin(input int idx);
    @(negedge clk);
    pin_i[idx] = 1'b1;
    wait_neg(3);
    pin_i[idx] = 1'b0;
    wait_neg(4);
  endtask

  task automatic tick_gap(output int gap);
    int t0;
    t0 = ticks;
    while (ticks < t0 + 2) @(negedge clk);
    gap = last_tick_cyc - prev_tick_cyc;
  endtask

  // R1
  task automatic t_reset;
    check(load_o == 16'h0, "R1 load", load_o, 0);
    check(cnt_o == 16'h0, "R1 count", cnt_o, 0);
    check(tick_o == 1'b0, "R1 tick", tick_o, 0);
  endtask

  // R2, R3
  task automatic t_write;
    write_cfg(16'h4003);
    check(load_o == 16'h4003, "R2 load readback", load_o, 16'h4003);
    check(cnt_o == 16'd3, "R3 preload", cnt_o, 3);
    check(cnt_o[15:14] == 2'b00, "R8 upper bits", cnt_o[15:14], 0);
  endtask

  // R4, R6 on pin 0, factor 3
  task automatic t_pin0_steps;
    int t0;
    write_cfg(16'h4003);
    t0 = ticks;
    @(negedge clk);
    pin_i[0] = 1'b1;
    wait_neg(2);
    check(cnt_o == 16'd3, "R6 latency not early", cnt_o, 3);
    wait_neg(1);
    check(cnt_o == 16'd2, "R6 latency due", cnt_o, 2);
    pin_i[0] = 1'b0;
    wait_neg(4);
    pulse_pin(0);
    check(cnt_o == 16'd1, "R4 step", cnt_o, 1);
    pulse_pin(0);
    check(cnt_o == 16'd0, "R4 zero", cnt_o, 0);
    check(ticks == t0, "R4 no early tick", ticks - t0, 0);
    pulse_pin(0);
    check(cnt_o == 16'd3, "R4 reload", cnt_o, 3);
    check(ticks == t0 + 1, "R4 one tick", ticks - t0, 1);
  endtask

  // R3 write mid-count
  task automatic t_rewrite;
    int t0;
    write_cfg(16'h4003);
    pulse_pin(0);
    t0 = ticks;
    write_cfg(16'h4006);
    check(cnt_o == 16'd6, "R3 rewrite preload", cnt_o, 6);
    wait_neg(3);
    check(ticks == t0, "R3 no tick on write", ticks - t0, 0);
  endtask

  // R7
  task automatic t_unselected;
    int t0;
    write_cfg(16'h4005);
    t0 = ticks;
    for (int k = 0; k < 3; k++) begin
      pulse_pin(1);
      pulse_pin(2);
    end
    check(cnt_o == 16'd5, "R7 count held", cnt_o, 5);
    check(ticks == t0, "R7 no tick", ticks - t0, 0);
  endtask

  // R6 pin 1, factor 2
  task automatic t_pin1;
    int t0;
    write_cfg(16'h8002);
    t0 = ticks;
    for (int k = 0; k < 9; k++) pulse_pin(1);
    check(ticks == t0 + 3, "R6 pin1 ticks", ticks - t0, 3);
    check(cnt_o == 16'd2, "R6 pin1 count", cnt_o, 2);
  endtask

  // R10 factor zero on pin 2
  task automatic t_pin2_zero;
    int t0;
    write_cfg(16'hC000);
    t0 = ticks;
    for (int k = 0; k < 4; k++) pulse_pin(2);
    check(ticks == t0 + 4, "R10 factor zero pin2", ticks - t0, 4);
    check(cnt_o == 16'd0, "R10 count zero", cnt_o, 0);
  endtask

  // R5, R9, R10 internal source
  task automatic t_internal;
    int gap;
    write_cfg(16'h0004);
    tick_gap(gap);
    check(gap == 10, "R5 internal F=4", gap, 10);
    write_cfg(16'h0000);
    tick_gap(gap);
    check(gap == 2, "R9 R10 internal F=0", gap, 2);
    write_cfg(16'h3FFF);
    check(load_o == 16'h3FFF, "R2 max factor", load_o, 16'h3FFF);
    tick_gap(gap);
    check(gap == 32768, "R10 internal F=max", gap, 32768);
  endtask

  initial begin
    checks = 0; failures = 0; cyc = 0; ticks = 0;
    last_tick_cyc = 0; prev_tick_cyc = 0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; pin_i = '0;
    wait_neg(3);
    t_reset();
    rst_n = 1'b1;
    wait_neg(4);
    t_write();
    t_pin0_steps();
    t_rewrite();
    t_unselected();
    t_pin1();
    t_pin2_zero();
    t_internal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1900000;
    checks   = checks + 1;
    failures = failures + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule